// File: doc/BRIEF.md
# Descriptor ring DMA channel engine

A single DMA channel that works through a circular ring of 128-bit descriptors held in a local descriptor memory. Software fills ring slots and then writes a new head index. The engine fetches the slot at its tail, decodes it as either a memory copy or a status write, and carries out the work over a one-outstanding memory request port. It then advances the tail index, which software reads back to learn how far the ring has retired.

Copies move data in chunks. A group of up to `BUF_WORDS` bus words is read into a small staging buffer and then written out before the next group is read. A status write stores one 64-bit value and, when its descriptor asks for it, raises a one-cycle interrupt after the write is acknowledged. A head write that repeats the current head value means the ring was filled and overrun, so it sets a sticky error flag. A descriptor with an unknown type code sets the same flag and stops the channel. Toggling the enable low and then high clears both the flag and the stop.

Descriptor layout, word 0 in bits 63:0 and word 1 in bits 127:64:
- Word 1 bits 63:60 hold the type. Type 1 is a copy and type 2 is a status write.
- For a copy, word 0 bits 45:0 hold the source byte address and bits 59:46 hold the length in 64-byte units. Word 1 bits 45:0 hold the destination byte address.
- For a status write, word 0 is the value to write and word 1 bits 45:0 hold the target address. Word 1 bit 59 requests an interrupt.

Top module: `dma_ring_chan`

## Requirements
- R1: After reset the tail index is 0, err_o and irq_o are low and no memory request is raised. quiesced_o is high while en_i is low.
- R2: A type-1 descriptor (word1[63:60]=1) copies L×64 bytes, where L is word0[59:46]. It reads from word0[45:0] and writes to word1[45:0], one 8-byte word at a time in ascending address order. A request is held with its address unchanged until it is granted.
- R3: A type-2 descriptor (word1[63:60]=2) performs exactly one write of word0 to address word1[45:0].
- R4: irq_o pulses for one cycle when a type-2 descriptor with word1[59]=1 retires. It does not pulse for copies or for status writes whose bit 59 is clear.
- R5: After a head write, descriptors are processed in ring order from the tail up to, but not including, the new head. Indices wrap modulo RING_DEPTH.
- R6: A head write equal to the current head sets err_o. The head is left unchanged and no further descriptor is processed.
- R7: A descriptor whose type is neither 1 nor 2 sets err_o and stops the channel: the tail does not advance, there is no memory traffic and quiesced_o is high. A rising edge of en_i clears err_o and the stop, and the slot is fetched again.
- R8: The tail advances by exactly one per retired descriptor, and only after every write of that descriptor has been acknowledged.
- R9: A copy with length 0 retires without any memory request.
- R10: With en_i low, the engine finishes the descriptor in progress, fetches no further descriptor and raises quiesced_o. Raising en_i resumes processing.
- R11: During a copy, no more than BUF_WORDS reads are issued between two writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; a rising edge clears error and stop |
| head_we_i | input | 1 | Head index write strobe |
| head_i | input | IDX_W | New head index |
| tail_o | output | IDX_W | Tail (completion) index |
| err_o | output | 1 | Sticky channel error |
| irq_o | output | 1 | Completion interrupt pulse |
| quiesced_o | output | 1 | Idle and either disabled or stopped |
| desc_re_o | output | 1 | Descriptor memory read enable |
| desc_idx_o | output | IDX_W | Descriptor slot to read |
| desc_data_i | input | 128 | Descriptor data, valid one cycle after read |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| mem_wack_i | input | 1 | Write acknowledged |

## Verification
The bench builds the channel with RING_DEPTH=8 and BUF_WORDS=4, with the other parameters left at their defaults. An 8-slot ring lets a short run write past the last slot and wrap the head and tail indices back to the start. A 4-word staging buffer splits a two-unit copy into four read-then-write chunks, which exercises the chunk boundary repeatedly. The memory model varies its grant and response latency, so the bench also sees requests held waiting for a grant and acknowledgements that arrive late.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int DESC_W   = 128;
  localparam int KIND_LSB = 60;
  localparam int IRQ_BIT  = 59;
  localparam int LEN_LSB  = 46;

  typedef enum logic [3:0] {
    KIND_COPY = 4'd1,
    KIND_STAT = 4'd2
  } desc_kind_e;

  typedef enum logic [1:0] {CH_IDLE, CH_FETCH, CH_BUSY} chan_st_e;

  typedef enum logic [2:0] {
    MV_IDLE, MV_RD_REQ, MV_RD_WAIT, MV_WR_REQ, MV_WR_WAIT
  } mover_st_e;
endpackage

// File: rtl/dma_ring_ptrs.sv
module dma_ring_ptrs #(
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             head_we_i,
  input  logic [IDX_W-1:0] head_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             pending_o,
  output logic             repeat_o
);
  logic [IDX_W-1:0] head_q, tail_q;

  assign repeat_o  = head_we_i && (head_i == head_q);
  assign pending_o = head_q != tail_q;
  assign head_o    = head_q;
  assign tail_o    = tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (head_we_i && !repeat_o) head_q <= head_i;
      // power-of-two depth: wrap is free
      if (adv_i) tail_q <= tail_q + 1'b1;
    end
  end

  // R5
  adv_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (head_q != tail_q));
endmodule

// File: rtl/dma_ring_mover.sv
module dma_ring_mover import dma_ring_pkg::*; #(
  parameter int ADDR_W    = 46,
  parameter int DATA_W    = 64,
  parameter int WCNT_W    = 17,
  parameter int BUF_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              imm_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [WCNT_W-1:0] nwords_i,
  input  logic [DATA_W-1:0] imm_data_i,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_wack_i
);
  localparam int KW   = $clog2(BUF_WORDS + 1);
  localparam int BI_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(DATA_W / 8);
  localparam logic [WCNT_W-1:0] BUF_N = WCNT_W'(BUF_WORDS);

  function automatic logic [KW-1:0] chunk_of(input logic [WCNT_W-1:0] r);
    return (r < BUF_N) ? KW'(r) : KW'(BUF_WORDS);
  endfunction

  mover_st_e         st_q;
  logic [ADDR_W-1:0] rd_a, wr_a;
  logic [WCNT_W-1:0] rem_q;
  logic [KW-1:0]     k_q, n_q, k_nx;
  logic              imm_q, done_q;
  logic [DATA_W-1:0] wdat_q;
  logic [DATA_W-1:0] stage_q [BUF_WORDS];
  logic [BI_W-1:0]   bi;

  assign bi          = k_q[BI_W-1:0];
  assign k_nx        = k_q + KW'(1);
  assign done_o      = done_q;
  assign mem_req_o   = (st_q == MV_RD_REQ) || (st_q == MV_WR_REQ);
  assign mem_we_o    = st_q == MV_WR_REQ;
  assign mem_addr_o  = mem_we_o ? wr_a : rd_a;
  assign mem_wdata_o = imm_q ? wdat_q : stage_q[bi];

  always_ff @(posedge clk_i) begin
    if (st_q == MV_RD_WAIT && mem_rvalid_i) stage_q[bi] <= mem_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= MV_IDLE;
      rd_a   <= '0;
      wr_a   <= '0;
      rem_q  <= '0;
      k_q    <= '0;
      n_q    <= '0;
      imm_q  <= 1'b0;
      wdat_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        MV_IDLE: if (start_i) begin
          rd_a   <= src_i;
          wr_a   <= dst_i;
          imm_q  <= imm_i;
          wdat_q <= imm_data_i;
          k_q    <= '0;
          rem_q  <= nwords_i;
          n_q    <= imm_i ? KW'(1) : chunk_of(nwords_i);
          if (imm_i)               st_q   <= MV_WR_REQ;
          else if (nwords_i == '0) done_q <= 1'b1;
          else                     st_q   <= MV_RD_REQ;
        end
        MV_RD_REQ: if (mem_gnt_i) st_q <= MV_RD_WAIT;
        MV_RD_WAIT: if (mem_rvalid_i) begin
          rd_a <= rd_a + STEP;
          if (k_nx == n_q) begin
            k_q  <= '0;
            st_q <= MV_WR_REQ;
          end else begin
            k_q  <= k_nx;
            st_q <= MV_RD_REQ;
          end
        end
        MV_WR_REQ: if (mem_gnt_i) st_q <= MV_WR_WAIT;
        MV_WR_WAIT: if (mem_wack_i) begin
          wr_a <= wr_a + STEP;
          if (k_nx == n_q) begin
            k_q <= '0;
            if (imm_q || rem_q == WCNT_W'(n_q)) begin
              done_q <= 1'b1;
              st_q   <= MV_IDLE;
            end else begin
              rem_q <= rem_q - WCNT_W'(n_q);
              n_q   <= chunk_of(rem_q - WCNT_W'(n_q));
              st_q  <= MV_RD_REQ;
            end
          end else begin
            k_q  <= k_nx;
            st_q <= MV_WR_REQ;
          end
        end
        default: st_q <= MV_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R9
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !imm_i && (nwords_i == '0) |=> done_o && !mem_req_o);
endmodule

// File: rtl/dma_ring_chan.sv
module dma_ring_chan import dma_ring_pkg::*; #(
  parameter int RING_DEPTH  = 128,
  parameter int ADDR_W      = 46,
  parameter int DATA_W      = 64,
  parameter int LEN_W       = 14,
  parameter int ALIGN_SHIFT = 6,
  parameter int BUF_WORDS   = 4,
  localparam int IDX_W      = $clog2(RING_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              head_we_i,
  input  logic [IDX_W-1:0]  head_i,
  output logic [IDX_W-1:0]  tail_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              quiesced_o,
  output logic              desc_re_o,
  output logic [IDX_W-1:0]  desc_idx_o,
  input  logic [DESC_W-1:0] desc_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_wack_i
);
  localparam int WSHIFT = $clog2(DATA_W / 8);
  localparam int WCNT_W = LEN_W + ALIGN_SHIFT - WSHIFT;

  logic [IDX_W-1:0] head, tail;
  logic             pending, head_rep, adv;

  dma_ring_ptrs #(.IDX_W(IDX_W)) u_ptrs (
    .clk_i, .rst_ni, .head_we_i, .head_i,
    .adv_i(adv), .head_o(head), .tail_o(tail),
    .pending_o(pending), .repeat_o(head_rep)
  );

  logic [63:0]       w0, w1;
  logic [3:0]        kind;
  logic [LEN_W-1:0]  units;
  logic [WCNT_W-1:0] nwords;
  assign w0     = desc_data_i[63:0];
  assign w1     = desc_data_i[127:64];
  assign kind   = w1[KIND_LSB +: 4];
  assign units  = w0[LEN_LSB +: LEN_W];
  assign nwords = WCNT_W'(units) << (ALIGN_SHIFT - WSHIFT);

  chan_st_e st_q, st_d;
  logic en_q, halt_q, err_q, irq_q, irq_want_q;
  logic mv_start, mv_imm, mv_done, bad, en_rise;

  assign en_rise = en_i && !en_q;

  always_comb begin
    st_d      = st_q;
    desc_re_o = 1'b0;
    mv_start  = 1'b0;
    mv_imm    = 1'b0;
    adv       = 1'b0;
    bad       = 1'b0;
    case (st_q)
      CH_IDLE: if (en_i && !halt_q && pending) begin
        desc_re_o = 1'b1;
        st_d      = CH_FETCH;
      end
      CH_FETCH: begin
        if (kind == KIND_COPY) begin
          mv_start = 1'b1;
          st_d     = CH_BUSY;
        end else if (kind == KIND_STAT) begin
          mv_start = 1'b1;
          mv_imm   = 1'b1;
          st_d     = CH_BUSY;
        end else begin
          bad  = 1'b1;
          st_d = CH_IDLE;
        end
      end
      CH_BUSY: if (mv_done) begin
        adv  = 1'b1;
        st_d = CH_IDLE;
      end
      default: st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= CH_IDLE;
      en_q       <= 1'b0;
      halt_q     <= 1'b0;
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
      irq_want_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_i;
      irq_q <= adv && irq_want_q;
      if (mv_start) irq_want_q <= mv_imm && w1[IRQ_BIT];
      if (bad)          halt_q <= 1'b1;
      else if (en_rise) halt_q <= 1'b0;
      if (bad || head_rep) err_q <= 1'b1;
      else if (en_rise)    err_q <= 1'b0;
    end
  end

  dma_ring_mover #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WCNT_W(WCNT_W), .BUF_WORDS(BUF_WORDS)
  ) u_mover (
    .clk_i, .rst_ni,
    .start_i(mv_start), .imm_i(mv_imm),
    .src_i(w0[ADDR_W-1:0]), .dst_i(w1[ADDR_W-1:0]),
    .nwords_i(nwords), .imm_data_i(w0[DATA_W-1:0]),
    .done_o(mv_done),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i, .mem_wack_i
  );

  assign tail_o     = tail;
  assign desc_idx_o = tail;
  assign err_o      = err_q;
  assign irq_o      = irq_q;
  assign quiesced_o = (st_q == CH_IDLE) && (!en_i || halt_q);

  // R8
  tail_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tail_o) |-> $past(mv_done));

  // R4
  irq_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mv_done));

  // R6
  repeat_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_we_i && (head_i == head) |=> err_o);

  // R10
  quiet_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiesced_o |-> !mem_req_o);

  // R7
  halt_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_q |-> !desc_re_o);
endmodule

// File: tb/dma_ring_chan_bench.sv
`timescale 1ns/1ps
module dma_ring_chan_bench;
  localparam int DEPTH = 8;
  localparam int BUFW  = 4;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic head_we_i = 1'b0;
  logic [IW-1:0] head_i = '0;
  logic [IW-1:0] tail_o;
  logic err_o, irq_o, quiesced_o, desc_re_o;
  logic [IW-1:0] desc_idx_o;
  logic [127:0] desc_q = '0;
  logic mem_req_o, mem_we_o;
  logic [45:0] mem_addr_o;
  logic [63:0] mem_wdata_o;
  logic mem_gnt_i;
  logic mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic mem_wack_i = 1'b0;

  always #2.5 clk = ~clk;

  dma_ring_chan #(.RING_DEPTH(DEPTH), .BUF_WORDS(BUFW)) u_dma_ring_chan (
    .clk_i(clk), .rst_ni, .en_i, .head_we_i, .head_i, .tail_o, .err_o,
    .irq_o, .quiesced_o, .desc_re_o, .desc_idx_o, .desc_data_i(desc_q),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_gnt_i,
    .mem_rvalid_i, .mem_rdata_i, .mem_wack_i
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] src_val(input logic [45:0] a);
    return {a[31:0] ^ 32'hA5A5_0000, ~a[31:0]};
  endfunction

  // descriptor memory, one-cycle read
  logic [127:0] dmem [DEPTH];
  always @(posedge clk) if (desc_re_o) desc_q <= dmem[desc_idx_o];

  // memory model with varying latency
  int cyc = 0;
  logic gnt_ok = 1'b0;
  logic pend = 1'b0, pwe = 1'b0;
  logic [45:0] paddr = '0;
  int dly_cnt = 0;
  assign mem_gnt_i = mem_req_o && gnt_ok;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    gnt_ok <= (cyc % 3) != 0;
    mem_rvalid_i <= 1'b0;
    mem_wack_i <= 1'b0;
    if (pend) begin
      if (dly_cnt == 0) begin
        pend <= 1'b0;
        if (pwe) mem_wack_i <= 1'b1;
        else begin
          mem_rvalid_i <= 1'b1;
          mem_rdata_i <= src_val(paddr);
        end
      end else dly_cnt <= dly_cnt - 1;
    end
    if (mem_req_o && mem_gnt_i) begin
      pend <= 1'b1;
      dly_cnt <= cyc % 2;
      pwe <= mem_we_o;
      paddr <= mem_addr_o;
    end
  end

  // reference model state
  logic [45:0] exp_addr[$];
  logic [63:0] exp_data[$];
  bit          exp_irq[$];
  string       exp_tag[$];
  int          retire_end[$];
  int writes_total = 0, acked = 0, owed = 0, irq_seen = 0;
  int reads_seen = 0, exp_reads = 0, rd_run = 0;
  logic [IW-1:0] prev_tail = '0;

  task automatic push_wr(input logic [45:0] a, input logic [63:0] d, input bit irq, input string tag);
    exp_addr.push_back(a);
    exp_data.push_back(d);
    exp_irq.push_back(irq);
    exp_tag.push_back(tag);
    writes_total++;
  endtask

  task automatic put_copy(input int idx, input logic [45:0] s, input logic [45:0] d, input int units);
    dmem[idx] = {4'h1, 1'b0, 13'h0, d, 4'h0, 14'(units), s};
    for (int i = 0; i < units * 8; i++)
      push_wr(d + 46'(8 * i), src_val(s + 46'(8 * i)), 1'b0, "R2");
    exp_reads += units * 8;
    retire_end.push_back(writes_total);
  endtask

  task automatic put_stat(input int idx, input logic [63:0] v, input logic [45:0] d, input bit irq);
    dmem[idx] = {4'h2, irq, 13'h0, d, v};
    push_wr(d, v, irq, "R3");
    retire_end.push_back(writes_total);
  endtask

  // monitor, sampled away from the active edge
  always @(negedge clk) if (rst_ni) begin
    if (mem_req_o && mem_gnt_i) begin
      if (mem_we_o) begin
        rd_run = 0;
        if (exp_addr.size() == 0) chk(1'b0, "R5 unexpected write", longint'(mem_addr_o), 0);
        else begin
          chk(mem_addr_o == exp_addr[0], exp_tag[0], longint'(mem_addr_o), longint'(exp_addr[0]));
          chk(mem_wdata_o == exp_data[0], exp_tag[0], longint'(mem_wdata_o), longint'(exp_data[0]));
          if (exp_irq[0]) owed++;
          void'(exp_addr.pop_front());
          void'(exp_data.pop_front());
          void'(exp_irq.pop_front());
          void'(exp_tag.pop_front());
        end
      end else begin
        reads_seen++;
        rd_run++;
        chk(rd_run <= BUFW, "R11", rd_run, BUFW);
      end
    end
    if (mem_wack_i) acked++;
    if (irq_o) begin
      irq_seen++;
      chk(owed > 0, "R4 spurious irq", owed, 1);
      if (owed > 0) owed--;
    end
    if (tail_o != prev_tail) begin
      chk(tail_o == IW'(prev_tail + 1'b1), "R8 step", tail_o, IW'(prev_tail + 1'b1));
      if (retire_end.size() == 0) chk(1'b0, "R8 unexpected retire", tail_o, prev_tail);
      else begin
        chk(acked >= retire_end[0], "R8 retire before ack", acked, retire_end[0]);
        void'(retire_end.pop_front());
      end
      prev_tail = tail_o;
    end
  end

  task automatic head_wr(input int v);
    @(negedge clk);
    head_we_i = 1'b1;
    head_i = IW'(v);
    @(negedge clk);
    head_we_i = 1'b0;
  endtask

  task automatic wait_tail(input int v, input string tag);
    int n = 0;
    while (tail_o != IW'(v) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(tail_o == IW'(v), tag, tail_o, v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_en();
    @(negedge clk) en_i = 1'b0;
    idle(2);
    en_i = 1'b1;
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) dmem[i] = '0;
    idle(4);
    rst_ni = 1'b1;
    idle(2);
    // R1
    chk(tail_o == 0, "R1 tail", tail_o, 0);
    chk(!err_o, "R1 err", err_o, 0);
    chk(!irq_o, "R1 irq", irq_o, 0);
    chk(quiesced_o, "R1 quiesced", quiesced_o, 1);
    chk(!mem_req_o, "R1 req", mem_req_o, 0);

    en_i = 1'b1;
    idle(2);
    chk(!quiesced_o, "R10 enabled", quiesced_o, 0);
    put_copy(0, 46'h1000, 46'h8000, 1);
    put_stat(1, 64'hDEAD_BEEF_0123_4567, 46'h9000, 1'b1);
    put_copy(2, 46'h2000, 46'hA000, 0);   // R9 zero length
    put_stat(3, 64'h0000_0000_0000_1111, 46'h9008, 1'b0);
    head_wr(4);
    wait_tail(4, "R5 first batch");
    idle(4);
    chk(exp_addr.size() == 0, "R2 writes left", exp_addr.size(), 0);
    chk(reads_seen == exp_reads, "R9 read count", reads_seen, exp_reads);
    chk(irq_seen == 1, "R4 irq count", irq_seen, 1);

    // R5 wrap around the ring end
    put_copy(4, 46'h3000, 46'hB000, 2);
    put_stat(5, 64'h5555_AAAA_5555_AAAA, 46'h9010, 1'b1);
    put_copy(6, 46'h4000, 46'hC000, 1);
    put_stat(7, 64'h7777, 46'h9018, 1'b0);
    put_copy(0, 46'h5000, 46'hD000, 1);
    put_stat(1, 64'h1234_5678_9ABC_DEF0, 46'h9020, 1'b1);
    head_wr(2);
    wait_tail(2, "R5 wrap");
    idle(4);
    chk(exp_addr.size() == 0, "R5 writes left", exp_addr.size(), 0);
    chk(irq_seen == 3, "R4 irq count wrap", irq_seen, 3);
    chk(reads_seen == exp_reads, "R2 read count", reads_seen, exp_reads);
    chk(!err_o, "R6 no err yet", err_o, 0);

    // R6 repeated head value
    head_wr(2);
    chk(err_o, "R6 err set", err_o, 1);
    idle(20);
    chk(tail_o == 2, "R6 tail held", tail_o, 2);
    toggle_en();
    chk(!err_o, "R7 err cleared by enable", err_o, 0);

    // R7 unknown type stops the channel
    dmem[2] = {4'h5, 60'h0, 64'h0};
    head_wr(3);
    idle(20);
    chk(err_o, "R7 err", err_o, 1);
    chk(tail_o == 2, "R7 tail held", tail_o, 2);
    chk(quiesced_o, "R7 halted", quiesced_o, 1);
    put_stat(2, 64'hCAFE_F00D_0000_0001, 46'h9028, 1'b1);
    toggle_en();
    wait_tail(3, "R7 resume");
    idle(4);
    chk(!err_o, "R7 err clear", err_o, 0);
    chk(irq_seen == 4, "R4 irq after resume", irq_seen, 4);

    // R10 disable in the middle of a copy
    put_copy(3, 46'h6000, 46'hE000, 3);
    put_stat(4, 64'h4444, 46'h9030, 1'b0);
    head_wr(5);
    begin
      int n = 0;
      while (!mem_req_o && n < 1000) begin
        @(negedge clk);
        n++;
      end
    end
    en_i = 1'b0;
    begin
      int n = 0;
      while (!quiesced_o && n < 5000) begin
        @(negedge clk);
        n++;
      end
    end
    chk(quiesced_o, "R10 quiesced", quiesced_o, 1);
    chk(tail_o == 4, "R10 finished current", tail_o, 4);
    chk(exp_addr.size() == 1, "R10 next held", exp_addr.size(), 1);
    idle(20);
    chk(tail_o == 4, "R10 stays stopped", tail_o, 4);
    en_i = 1'b1;
    wait_tail(5, "R10 resume");
    idle(4);
    chk(exp_addr.size() == 0, "R10 writes left", exp_addr.size(), 0);
    chk(owed == 0, "R4 irq owed", owed, 0);
    chk(retire_end.size() == 0, "R8 retires left", retire_end.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule